// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Unit

This block applies a gamma curve to a pixel stream that may belong to any of several display channels. For each channel it keeps one 8-bit ramp per colour component. All ramps sit in one shared linear table. When a channel has gamma turned on, each colour component of its pixels is replaced by the table entry that the component value selects. When gamma is off, the pixel passes through unchanged. Both paths have the same fixed latency.

Software fills the table through two write ports. The first is a pointer register, which holds a table address, an auto-advance flag and a force-power flag. The second is a data port that writes one table entry at the pointer. With auto-advance set, a whole ramp set can be streamed in as back-to-back data writes.

The table store is powered only while at least one channel uses gamma or the force-power flag is set. While it is unpowered, data-port writes are dropped and its contents are treated as stale.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, pix_valid_o, pix_sync_o and pix_rgb_o are 0, the pointer is 0, and auto-advance and force-power are both off.
- R2: The entry for channel c, component k and input value v is at table word c*768 + k*256 + v. Component k is 0 for red, 1 for green and 2 for blue. On the pixel buses, red is bits [23:16], green is [15:8] and blue is [7:0].
- R3: A pointer write loads the address from cfg_addr_wdata[11:0], auto-advance from bit 31 and force-power from bit 30. A data write stores cfg_data_wdata at the pointer when the table is powered.
- R4: With auto-advance on, every data write moves the pointer up by one. The pointer wraps from word 2303 to word 0.
- R5: With auto-advance off, data writes leave the pointer unchanged, so repeated writes all land on the same word.
- R6: For a channel whose gamma enable is 1, each output component equals the table entry that R2 selects for that channel, that component and that input value.
- R7: For a channel whose enable is 0, or for a channel number of 3 or more, the output pixel equals the input pixel.
- R8: pix_valid_o, pix_sync_o and pix_rgb_o follow the inputs by exactly two clock cycles on both the lookup path and the pass-through path.
- R9: The table is powered when any bit of ch_gamma_en is 1 or force-power is on. Data writes while it is unpowered change no entry, but they still advance the pointer under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_wr | input | 1 | Pointer register write strobe |
| cfg_addr_wdata | input | 32 | Pointer value: [31] auto-advance, [30] force-power, [11:0] address |
| cfg_data_wr | input | 1 | Data port write strobe |
| cfg_data_wdata | input | 8 | Table entry to write |
| ch_gamma_en | input | 3 | Per-channel gamma enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_sync_i | input | 1 | Input sync marker |
| pix_ch_i | input | 2 | Channel of the input pixel |
| pix_rgb_i | input | 24 | Input pixel, red in the top byte |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_sync_o | output | 1 | Delayed sync marker |
| pix_rgb_o | output | 24 | Corrected or passed-through pixel |

## Verification
The assertions check three things on every cycle. First, the pointer steps by exactly one, wraps at the last word, or holds, as the auto-advance flag requires. Second, valid and sync reach the output one stage after the middle register. Third, a pixel of a disabled channel reaches the output unchanged.

Some behaviour can only be shown by the bench's scenarios. These are the correct table layout across channels and components, the value actually returned by a lookup, and the effect of auto-advance over a full load. They also include the state of the pointer after reset, and the loss of data-port writes while the table is unpowered. The bench shows that lost write by reading the affected entries back through later lookups.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int COMP_N = 3;
  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;
  localparam int PTR_INC_BIT   = 31;
  localparam int PTR_FORCE_BIT = 30;
endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl #(
  parameter int AW        = 12,
  parameter int TBL_WORDS = 2304
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [31:0]   addr_wdata,
  input  logic          data_wr,
  output logic [AW-1:0] ptr,
  output logic          force_on
);
  import gamma_lut_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(TBL_WORDS - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          inc_q, inc_d;
  logic          frc_q, frc_d;
  logic          ld_en;
  logic          unused_bits;

  assign unused_bits = ^addr_wdata[PTR_FORCE_BIT-1:AW];

  always_comb begin
    ptr_d = ptr_q;
    inc_d = inc_q;
    frc_d = frc_q;
    ld_en = 1'b0;
    if (addr_wr) begin
      ld_en = 1'b1;
      ptr_d = addr_wdata[AW-1:0];
      inc_d = addr_wdata[PTR_INC_BIT];
      frc_d = addr_wdata[PTR_FORCE_BIT];
    end else if (data_wr && inc_q) begin
      ld_en = 1'b1;
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inc_q <= 1'b0;
      frc_q <= 1'b0;
    end else if (ld_en) begin
      ptr_q <= ptr_d;
      inc_q <= inc_d;
      frc_q <= frc_d;
    end
  end

  assign ptr      = ptr_q;
  assign force_on = frc_q;

  // R4: single step while auto-advancing
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && inc_q && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R4: wrap from the last word
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && inc_q && ptr_q == LAST) |=> (ptr_q == '0));
  // R5: pointer holds without auto-advance
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && !inc_q) |=> $stable(ptr_q));
  // R3: pointer write loads the address field
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (ptr_q == $past(addr_wdata[AW-1:0])));
endmodule

// File: rtl/gamma_table_mem.sv
module gamma_table_mem #(
  parameter int DW        = 8,
  parameter int AW        = 12,
  parameter int TBL_WORDS = 2304,
  parameter int PORTS     = 3
) (
  input  logic                      clk,
  input  logic                      pwr_on,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [PORTS-1:0][AW-1:0]  rd_addr,
  output logic [PORTS-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] mem [TBL_WORDS];
  logic          wr_go;

  assign wr_go = wr_en && pwr_on && (wr_addr < AW'(TBL_WORDS));

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  for (genvar k = 0; k < PORTS; k++) begin : g_rd
    always_comb begin
      rd_data[k] = '0;
      if (pwr_on && rd_addr[k] < AW'(TBL_WORDS)) rd_data[k] = mem[rd_addr[k]];
    end
  end
endmodule

// File: rtl/gamma_pix_pipe.sv
module gamma_pix_pipe #(
  parameter int NUM_CH  = 3,
  parameter int DW      = 8,
  parameter int CHW     = 2,
  parameter int AW      = 12,
  parameter int ENTRIES = 256
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      pix_valid_i,
  input  logic                                      pix_sync_i,
  input  logic [CHW-1:0]                            pix_ch_i,
  input  logic [gamma_lut_pkg::COMP_N*DW-1:0]       pix_rgb_i,
  input  logic [NUM_CH-1:0]                         ch_en,
  output logic [gamma_lut_pkg::COMP_N-1:0][AW-1:0]  lut_addr,
  input  logic [gamma_lut_pkg::COMP_N-1:0][DW-1:0]  lut_data,
  output logic                                      pix_valid_o,
  output logic                                      pix_sync_o,
  output logic [gamma_lut_pkg::COMP_N*DW-1:0]       pix_rgb_o
);
  import gamma_lut_pkg::*;
  localparam int RGB_W = COMP_N * DW;
  localparam logic [AW-1:0] BLOCK = AW'(COMP_N * ENTRIES);

  logic             s1_valid_q, s1_sync_q, s1_en_q;
  logic [CHW-1:0]   s1_ch_q;
  logic [RGB_W-1:0] s1_rgb_q;
  logic             en_d;
  logic             out_valid_q, out_sync_q;
  logic [RGB_W-1:0] out_rgb_q, out_rgb_d, rgb_lut;

  always_comb begin
    en_d = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (pix_ch_i == CHW'(i)) en_d = ch_en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_sync_q  <= 1'b0;
      s1_en_q    <= 1'b0;
      s1_ch_q    <= '0;
      s1_rgb_q   <= '0;
    end else begin
      s1_valid_q <= pix_valid_i;
      s1_sync_q  <= pix_sync_i;
      if (pix_valid_i) begin
        s1_en_q  <= en_d;
        s1_ch_q  <= pix_ch_i;
        s1_rgb_q <= pix_rgb_i;
      end
    end
  end

  // component k: 0 red (top byte), 1 green, 2 blue
  for (genvar k = 0; k < COMP_N; k++) begin : g_comp
    assign lut_addr[k] = AW'(s1_ch_q) * BLOCK + AW'(k * ENTRIES)
                       + AW'(s1_rgb_q[(COMP_N-1-k)*DW +: DW]);
    assign rgb_lut[(COMP_N-1-k)*DW +: DW] = lut_data[k];
  end

  assign out_rgb_d = s1_en_q ? rgb_lut : s1_rgb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_sync_q  <= 1'b0;
      out_rgb_q   <= '0;
    end else begin
      out_valid_q <= s1_valid_q;
      out_sync_q  <= s1_sync_q;
      if (s1_valid_q) out_rgb_q <= out_rgb_d;
    end
  end

  assign pix_valid_o = out_valid_q;
  assign pix_sync_o  = out_sync_q;
  assign pix_rgb_o   = out_rgb_q;

  // R8: valid and sync leave one stage after the middle register
  a_r8_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |=> pix_valid_o);
  a_r8_sync_lat: assert property (@(posedge clk) disable iff (!rst_n)
    s1_sync_q |=> pix_sync_o);
  // R7: a disabled channel's pixel is untouched
  a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && !s1_en_q) |=> (pix_rgb_o == $past(s1_rgb_q)));
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
  parameter int NUM_CH = 3,
  parameter int DW     = 8,
  localparam int ENTRIES   = 1 << DW,
  localparam int TBL_WORDS = NUM_CH * gamma_lut_pkg::COMP_N * ENTRIES,
  localparam int AW        = $clog2(TBL_WORDS),
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RGB_W     = gamma_lut_pkg::COMP_N * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_addr_wr,
  input  logic [31:0]       cfg_addr_wdata,
  input  logic              cfg_data_wr,
  input  logic [DW-1:0]     cfg_data_wdata,
  input  logic [NUM_CH-1:0] ch_gamma_en,
  input  logic              pix_valid_i,
  input  logic              pix_sync_i,
  input  logic [CHW-1:0]    pix_ch_i,
  input  logic [RGB_W-1:0]  pix_rgb_i,
  output logic              pix_valid_o,
  output logic              pix_sync_o,
  output logic [RGB_W-1:0]  pix_rgb_o
);
  import gamma_lut_pkg::*;

  logic [1:0]                  rst_sync_q;
  logic                        rst_int_n;
  logic [AW-1:0]               ptr;
  logic                        force_on;
  logic                        pwr_on;
  logic [COMP_N-1:0][AW-1:0]   lut_addr;
  logic [COMP_N-1:0][DW-1:0]   lut_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pwr_on = (|ch_gamma_en) | force_on;

  gamma_addr_ctrl #(.AW(AW), .TBL_WORDS(TBL_WORDS)) u_addr (
    .clk(clk), .rst_n(rst_int_n),
    .addr_wr(cfg_addr_wr), .addr_wdata(cfg_addr_wdata),
    .data_wr(cfg_data_wr),
    .ptr(ptr), .force_on(force_on)
  );

  gamma_table_mem #(.DW(DW), .AW(AW), .TBL_WORDS(TBL_WORDS), .PORTS(COMP_N)) u_mem (
    .clk(clk), .pwr_on(pwr_on),
    .wr_en(cfg_data_wr), .wr_addr(ptr), .wr_data(cfg_data_wdata),
    .rd_addr(lut_addr), .rd_data(lut_data)
  );

  gamma_pix_pipe #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW), .AW(AW), .ENTRIES(ENTRIES)) u_pipe (
    .clk(clk), .rst_n(rst_int_n),
    .pix_valid_i(pix_valid_i), .pix_sync_i(pix_sync_i),
    .pix_ch_i(pix_ch_i), .pix_rgb_i(pix_rgb_i),
    .ch_en(ch_gamma_en),
    .lut_addr(lut_addr), .lut_data(lut_data),
    .pix_valid_o(pix_valid_o), .pix_sync_o(pix_sync_o), .pix_rgb_o(pix_rgb_o)
  );
endmodule

// File: tb/tb_gamma_lut_top.sv
module tb_gamma_lut_top;
  localparam int WORDS = 2304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_addr_wr, cfg_data_wr;
  logic [31:0] cfg_addr_wdata;
  logic [7:0]  cfg_data_wdata;
  logic [2:0]  ch_gamma_en;
  logic        pix_valid_i, pix_sync_i;
  logic [1:0]  pix_ch_i;
  logic [23:0] pix_rgb_i;
  logic        pix_valid_o, pix_sync_o;
  logic [23:0] pix_rgb_o;

  always #4 clk = ~clk;

  gamma_lut_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_wr(cfg_addr_wr), .cfg_addr_wdata(cfg_addr_wdata),
    .cfg_data_wr(cfg_data_wr), .cfg_data_wdata(cfg_data_wdata),
    .ch_gamma_en(ch_gamma_en),
    .pix_valid_i(pix_valid_i), .pix_sync_i(pix_sync_i),
    .pix_ch_i(pix_ch_i), .pix_rgb_i(pix_rgb_i),
    .pix_valid_o(pix_valid_o), .pix_sync_o(pix_sync_o), .pix_rgb_o(pix_rgb_o)
  );

  typedef struct {
    logic        sync;
    logic [23:0] rgb;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  int     checks = 0, failures = 0, cyc = 0;
  bit     mon_on = 0, done = 0;
  int     tb_mem [WORDS];
  int     tb_ptr;
  bit     tb_inc, tb_frc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (pix_valid_o) begin
        if (q.size() == 0) chk(0, "R8 unexpected output", 32'(pix_rgb_o), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, "R8 latency", 32'(cyc), 32'(e.due));
          chk(pix_rgb_o == e.rgb, e.tag, 32'(pix_rgb_o), 32'(e.rgb));
          chk(pix_sync_o == e.sync, "R8 sync", 32'(pix_sync_o), 32'(e.sync));
        end
      end else if (q.size() > 0 && q[0].due < cyc) begin
        chk(0, "R8 missing output", 0, 32'(q[0].due));
        void'(q.pop_front());
      end
    end
  end

  task automatic set_ptr(input int a, input bit inc, input bit frc);
    @(negedge clk);
    cfg_addr_wr = 1'b1;
    cfg_addr_wdata = {inc, frc, 18'd0, 12'(a)};
    tb_ptr = a; tb_inc = inc; tb_frc = frc;
    @(negedge clk);
    cfg_addr_wr = 1'b0;
  endtask

  task automatic put_data(input int d);
    @(negedge clk);
    cfg_data_wr = 1'b1;
    cfg_data_wdata = 8'(d);
    if ((tb_frc || (|ch_gamma_en)) && tb_ptr < WORDS) tb_mem[tb_ptr] = d & 255;
    if (tb_inc) tb_ptr = (tb_ptr == WORDS - 1) ? 0 : tb_ptr + 1;
    @(negedge clk);
    cfg_data_wr = 1'b0;
  endtask

  task automatic send_pix(input int ch, input logic [23:0] rgb, input bit sync, input string tag);
    exp_t e;
    @(negedge clk);
    pix_valid_i = 1'b1; pix_sync_i = sync; pix_ch_i = 2'(ch); pix_rgb_i = rgb;
    e.sync = sync; e.due = cyc + 2; e.tag = tag;
    if (ch < 3 && ch_gamma_en[ch]) begin
      for (int k = 0; k < 3; k++)
        e.rgb[(2-k)*8 +: 8] = 8'(tb_mem[ch*768 + k*256 + int'(rgb[(2-k)*8 +: 8])]);
    end else e.rgb = rgb;
    q.push_back(e);
    @(negedge clk);
    pix_valid_i = 1'b0; pix_sync_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int pattern(input int i);
    return (i * 37 + (i >> 8) * 11 + 5) & 255;
  endfunction

  initial begin
    rst_n = 1'b0;
    cfg_addr_wr = 0; cfg_data_wr = 0; cfg_addr_wdata = 0; cfg_data_wdata = 0;
    ch_gamma_en = 0; pix_valid_i = 0; pix_sync_i = 0; pix_ch_i = 0; pix_rgb_i = 0;
    tb_ptr = 0; tb_inc = 0; tb_frc = 0;
    for (int i = 0; i < WORDS; i++) tb_mem[i] = 0;
    idle(4);
    chk(pix_valid_o == 0, "R1 valid reset", 32'(pix_valid_o), 0);
    chk(pix_sync_o == 0, "R1 sync reset", 32'(pix_sync_o), 0);
    chk(pix_rgb_o == 0, "R1 rgb reset", 32'(pix_rgb_o), 0);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1;

    // R1/R5: pointer starts at word 0 without auto-advance
    ch_gamma_en = 3'b001;
    put_data(8'h5A);
    put_data(8'hC3);
    idle(2);
    send_pix(0, 24'h000000, 0, "R1 R5 pointer reset and hold");
    idle(3);
    ch_gamma_en = 3'b000;

    // R3/R4: full load with force-power and auto-advance
    set_ptr(0, 1, 1);
    for (int i = 0; i < WORDS; i++) put_data(pattern(i));
    idle(2);

    // R7: pass-through with all enables low (forced power)
    send_pix(0, 24'h123456, 1, "R7 passthrough ch0");
    send_pix(2, 24'hA0B1C2, 0, "R7 passthrough ch2");

    // R2/R6: lookups on each channel
    ch_gamma_en = 3'b111;
    send_pix(0, 24'h00FF80, 1, "R6 R2 lookup ch0");
    send_pix(1, 24'h102030, 0, "R6 R2 lookup ch1");
    send_pix(2, 24'hFF00FF, 0, "R6 R2 lookup ch2");
    send_pix(1, 24'hFFFFFF, 1, "R6 R2 lookup ch1 top");
    send_pix(3, 24'h445566, 0, "R7 channel out of range");
    ch_gamma_en = 3'b010;
    send_pix(0, 24'h778899, 0, "R7 disabled ch0");
    send_pix(1, 24'h778899, 0, "R6 enabled ch1");
    ch_gamma_en = 3'b111;
    idle(4);

    // R5: repeated writes without auto-advance hit one word
    set_ptr(5, 0, 0);
    put_data(8'h11);
    put_data(8'h22);
    idle(2);
    send_pix(0, 24'h050000, 0, "R5 same word");
    send_pix(0, 24'h060000, 0, "R5 next word untouched");

    // R4: wrap from last word to 0
    set_ptr(WORDS - 1, 1, 0);
    put_data(8'h33);
    put_data(8'h44);
    idle(2);
    send_pix(2, 24'h0000FF, 0, "R4 last word");
    send_pix(0, 24'h000000, 0, "R4 wrapped to word 0");
    idle(4);

    // R9: writes dropped while unpowered, pointer still advances
    ch_gamma_en = 3'b000;
    set_ptr(10, 1, 0);
    put_data(8'h99);
    put_data(8'h77);
    ch_gamma_en = 3'b001;
    put_data(8'h55);
    idle(2);
    send_pix(0, 24'h0A0000, 0, "R9 dropped write word 10");
    send_pix(0, 24'h0B0000, 0, "R9 dropped write word 11");
    send_pix(0, 24'h0C0000, 0, "R9 pointer advanced to 12");
    idle(6);

    chk(q.size() == 0, "R8 pending outputs", 32'(q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule